// File: doc/BRIEF.md
# Gated Timer/Counter Core

This block is a 16-bit up-counter that advances on ticks taken from one of four sources: the system clock divided by four, the system clock itself, rising edges of an asynchronous external pin, or single-cycle strobes from an alternate oscillator front end. The chosen source goes through a power-of-two prescaler before it reaches the count. Counting is qualified by a run bit and, if gating is selected, by a gate-active input produced elsewhere.

The host sees the count as two byte-wide views, high and low, that follow the live value. It can load either byte, which also resets the hidden prescaler. A compare unit nearby can zero the count with a trigger strobe, which turns the counter into a period timer. When the count wraps from all ones to zero, a sticky overflow flag is set. That flag, masked by an interrupt-enable input, drives the interrupt line.

Everything runs on one system clock. The external pin is brought into that domain through a synchronizer followed by an edge detector.

Top module: `gtc_core`

## Requirements
- R1: After reset the count is 0000h, and the overflow flag and the interrupt output are low.
- R2: With source code 01 (system clock) and prescale code 00, the count grows by one on every enabled clock.
- R3: With source code 00 (system clock divided by four), the count grows by exactly one for every four enabled clocks.
- R4: Prescale code n (00, 01, 10, 11) passes one increment for every 2^n source ticks. The count of ticks is taken from the last byte write.
- R5: With run_en=0 the count holds. With run_en=1 and gate_mode=0 it counts. With run_en=1 and gate_mode=1 it counts only while gate_act=1.
- R6: An increment from FFFFh gives 0000h and sets the overflow flag.
- R7: The overflow flag stays set until a cycle with ovf_clr=1. irq equals the flag while irq_en=1 and is low while irq_en=0.
- R8: evt_clr forces the count to 0000h and never sets the overflow flag, even when it coincides with an increment from FFFFh.
- R9: A write to either byte loads wr_data into that byte and wins over a coincident evt_clr. The other byte keeps its value. The write also clears the prescaler.
- R10: With source code 10, a rising edge of ext_pin counts only if a falling edge of the pin has been seen since the last reset, byte write, or cycle with run_en=0.
- R11: With source code 11, each cycle with alt_tick=1 is one source tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer on bit |
| gate_mode | input | 1 | 1: counting qualified by gate_act |
| gate_act | input | 1 | Gate active level from gate logic |
| src_sel | input | 2 | Count source: 00 clk/4, 01 clk, 10 pin, 11 alternate |
| div_sel | input | 2 | Prescale 1:1, 1:2, 1:4, 1:8 |
| ext_pin | input | 1 | Asynchronous external count pin |
| alt_tick | input | 1 | Alternate oscillator tick strobe |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_data | input | 8 | Byte write data |
| evt_clr | input | 1 | Special-event clear of the count |
| ovf_clr | input | 1 | Write-one-to-clear of the overflow flag |
| irq_en | input | 1 | Overflow interrupt enable |
| cnt_hi | output | 8 | Live high byte of the count |
| cnt_lo | output | 8 | Live low byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench first checks the prescaler. After a load it counts up to a known number of ticks and then confirms that the load reset the hidden divider. If the divider were not reset, the first increment after the load would come too early.

The wrap from FFFFh is driven with and without a coincident clear strobe. A design that raised the flag on a clear, or let the clear override a write, would show a wrong count or a spurious flag.

For the pin source, the bench raises the pin straight after a load and after a disable. A design that skipped the falling-edge arming would count one edge too many. A randomly mixed phase covers enable, gate, writes, clears and prescale changes against a bench model.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  typedef enum logic [1:0] {
    SRC_DIV4 = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_PIN  = 2'b10,
    SRC_ALT  = 2'b11
  } src_e;
endpackage

// File: rtl/gtc_tick_src.sv
module gtc_tick_src #(
  parameter int SYNC_STAGES = 2,
  parameter int SYS_DIV     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       ext_pin,
  input  logic       alt_tick,
  input  logic       disarm,
  output logic       tick
);
  import gtc_pkg::*;
  localparam int PH_W = $clog2(SYS_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYS_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   armed_q, armed_d;
  logic [PH_W-1:0]        ph_q, ph_d;
  logic                   pin_s, pin_rise, pin_fall;

  // synchronizer chain, one flop per stage
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign pin_rise = pin_s & ~prev_q;
  assign pin_fall = ~pin_s & prev_q;

  always_comb begin
    ph_d = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
    if (disarm)        armed_d = 1'b0;
    else if (pin_fall) armed_d = 1'b1;
    else               armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      ph_q    <= '0;
    end else begin
      prev_q  <= pin_s;
      armed_q <= armed_d;
      ph_q    <= ph_d;
    end
  end

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_DIV4: tick = (ph_q == PH_LAST);
      SRC_SYS:  tick = 1'b1;
      SRC_PIN:  tick = pin_rise & armed_q;
      SRC_ALT:  tick = alt_tick;
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             clr,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick_out
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(div_sel));
    tick_out = tick_in & ((pc_q & mask) == mask);
    if (clr)          pc_d = '0;
    else if (tick_in) pc_d = pc_q + PC_W'(1);
    else              pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               evt_clr,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   count,
  output logic               ovf_flag
);
  localparam int HB = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (wr_hi || wr_lo) begin
      if (wr_hi) cnt_d[CNT_W-1:HB] = wr_data;
      if (wr_lo) cnt_d[HB-1:0]     = wr_data;
    end else if (evt_clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + CNT_ONE;
      wrap  = &cnt_q;
    end
    flag_d = wrap | (flag_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign count    = cnt_q;
  assign ovf_flag = flag_q;
endmodule

// File: rtl/gtc_core.sv
module gtc_core #(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SYS_DIV     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               gate_mode,
  input  logic               gate_act,
  input  logic [1:0]         src_sel,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               ext_pin,
  input  logic               alt_tick,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               evt_clr,
  input  logic               ovf_clr,
  input  logic               irq_en,
  output logic [CNT_W/2-1:0] cnt_hi,
  output logic [CNT_W/2-1:0] cnt_lo,
  output logic               ovf_flag,
  output logic               irq
);
  localparam int HB = CNT_W / 2;

  logic             any_wr, cnt_en, src_tick, pre_tick;
  logic [CNT_W-1:0] count;

  assign any_wr = wr_hi | wr_lo;
  assign cnt_en = run_en & (~gate_mode | gate_act);

  gtc_tick_src #(.SYNC_STAGES(SYNC_STAGES), .SYS_DIV(SYS_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_pin(ext_pin),
    .alt_tick(alt_tick), .disarm(~run_en | any_wr), .tick(src_tick)
  );

  gtc_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_in(src_tick & cnt_en), .clr(any_wr),
    .div_sel(div_sel), .tick_out(pre_tick)
  );

  gtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(pre_tick), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .evt_clr(evt_clr), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag)
  );

  assign cnt_hi = count[CNT_W-1:HB];
  assign cnt_lo = count[HB-1:0];
  assign irq    = ovf_flag & irq_en;
endmodule

// File: rtl/gtc_core_chk.sv
module gtc_core_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_en,
  input logic               wr_hi,
  input logic               wr_lo,
  input logic [CNT_W/2-1:0] wr_data,
  input logic               evt_clr,
  input logic               ovf_clr,
  input logic [CNT_W/2-1:0] cnt_hi,
  input logic [CNT_W/2-1:0] cnt_lo,
  input logic               ovf_flag
);
  logic [CNT_W-1:0] cnt;
  assign cnt = {cnt_hi, cnt_lo};

  a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_hi && !wr_lo && !evt_clr) |=> $stable(cnt));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo && !evt_clr) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  a_r6_wrap_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == '1 && cnt == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !wr_hi && !wr_lo) |=> cnt == '0);

  a_r8_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !ovf_flag) |=> !ovf_flag);

  a_r9_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wr_data));
endmodule

bind gtc_core gtc_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_hi(wr_hi), .wr_lo(wr_lo),
  .wr_data(wr_data), .evt_clr(evt_clr), .ovf_clr(ovf_clr),
  .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag)
);

// File: tb/gtc_core_test.sv
module gtc_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 0, gate_mode = 0, gate_act = 0, ext_pin = 0, alt_tick = 0;
  logic [1:0] src_sel = 2'b01, div_sel = 2'b00;
  logic wr_hi = 0, wr_lo = 0, evt_clr = 0, ovf_clr = 0, irq_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt_hi, cnt_lo;
  logic ovf_flag, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state for the random phase
  logic [15:0] m_cnt;
  logic [2:0]  m_pc;
  logic        m_flag;

  always #4 clk = ~clk;

  gtc_core uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_mode(gate_mode),
    .gate_act(gate_act), .src_sel(src_sel), .div_sel(div_sel),
    .ext_pin(ext_pin), .alt_tick(alt_tick), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .evt_clr(evt_clr), .ovf_clr(ovf_clr),
    .irq_en(irq_en), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic logic [15:0] cur();
    return {cnt_hi, cnt_lo};
  endfunction

  function automatic int div_ratio(input logic [1:0] d);
    return 1 << d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input logic [15:0] exp);
    chk(cur() == exp, req, int'(cur()), int'(exp));
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write16(input logic [15:0] v);
    wr_hi = 1; wr_data = v[15:8]; step(1);
    wr_hi = 0; wr_lo = 1; wr_data = v[7:0]; step(1);
    wr_lo = 0;
  endtask

  // one model cycle from the inputs now applied (R2 R4 R5 R6 R7 R8 R9)
  task automatic model_step();
    logic en, wr, inc, wrap;
    logic [2:0] mask;
    en   = run_en & (!gate_mode | gate_act);
    wr   = wr_hi | wr_lo;
    mask = 3'(div_ratio(div_sel) - 1);
    inc  = en && !wr && ((m_pc & mask) == mask);
    wrap = inc && !evt_clr && (m_cnt == 16'hFFFF);
    if (wr) begin
      if (wr_hi) m_cnt[15:8] = wr_data;
      if (wr_lo) m_cnt[7:0]  = wr_data;
      m_pc = 3'd0;
    end else begin
      if (en) m_pc = m_pc + 3'd1;
      if (evt_clr)  m_cnt = 16'h0;
      else if (inc) m_cnt = m_cnt + 16'd1;
    end
    m_flag = wrap | (m_flag & !ovf_clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    void'($urandom(32'd1234));
    step(2);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk_cnt("R1 count", 16'h0);
    chk(ovf_flag == 0, "R1 flag", ovf_flag, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 every clock
    run_en = 1; src_sel = 2'b01; div_sel = 0;
    write16(16'h0010);
    step(10);
    chk_cnt("R2 sysclk", 16'h001A);

    // R3 divide by four, phase independent over 16 clocks
    src_sel = 2'b00;
    base = cur(); step(16);
    chk_cnt("R3 div4", base + 16'd4);

    // R4 prescale ratios after a load
    src_sel = 2'b01;
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      write16(16'h0000);
      step(20);
      chk_cnt("R4 prescale", 16'(20 / div_ratio(2'(d))));
    end
    // R9 load clears prescaler
    div_sel = 2'b11;
    write16(16'h0000); step(5);
    chk_cnt("R4 partial", 16'h0);
    write16(16'h0000); step(7);
    chk_cnt("R9 prescaler cleared", 16'h0);
    step(1);
    chk_cnt("R9 first after clear", 16'h1);

    // R5 enable table
    div_sel = 0; run_en = 0; gate_mode = 1; gate_act = 1;
    write16(16'd100); step(8);
    chk_cnt("R5 off", 16'd100);
    run_en = 1; gate_act = 0; step(8);
    chk_cnt("R5 gated closed", 16'd100);
    gate_act = 1; step(8);
    chk_cnt("R5 gated open", 16'd108);
    gate_mode = 0; gate_act = 0; step(8);
    chk_cnt("R5 free", 16'd116);

    // R6 R7 wrap and flag
    irq_en = 1;
    write16(16'hFFFE); step(1);
    chk(cur() == 16'hFFFF && !ovf_flag, "R6 before wrap", int'(cur()), 16'hFFFF);
    step(1);
    chk_cnt("R6 wrapped", 16'h0000);
    chk(ovf_flag == 1, "R6 flag", ovf_flag, 1);
    chk(irq == 1, "R7 irq on", irq, 1);
    run_en = 0; irq_en = 0; step(3);
    chk(ovf_flag == 1 && irq == 0, "R7 sticky masked", {ovf_flag, irq}, 2);
    ovf_clr = 1; step(1); ovf_clr = 0;
    chk(ovf_flag == 0, "R7 cleared", ovf_flag, 0);

    // R8 trigger clear on wrap
    write16(16'hFFFF);
    run_en = 1; evt_clr = 1; step(1); evt_clr = 0;
    chk_cnt("R8 cleared", 16'h0);
    chk(ovf_flag == 0, "R8 no flag", ovf_flag, 0);
    run_en = 0;

    // R9 write beats trigger
    write16(16'h1234);
    wr_lo = 1; wr_data = 8'h5A; evt_clr = 1; step(1);
    wr_lo = 0; evt_clr = 0;
    chk_cnt("R9 lo over clear", 16'h125A);
    wr_hi = 1; wr_data = 8'hC3; evt_clr = 1; step(1);
    wr_hi = 0; evt_clr = 0;
    chk_cnt("R9 hi over clear", 16'hC35A);

    // R10 pin arming
    run_en = 1; src_sel = 2'b10; div_sel = 0;
    write16(16'h0000);
    ext_pin = 1; step(4);
    chk_cnt("R10 first rise ignored", 16'h0);
    ext_pin = 0; step(4); ext_pin = 1; step(4);
    chk_cnt("R10 armed rise", 16'h1);
    ext_pin = 0; step(4); ext_pin = 1; step(4);
    chk_cnt("R10 second rise", 16'h2);
    run_en = 0; step(2); ext_pin = 0; step(4);
    run_en = 1; step(4); ext_pin = 1; step(4);
    chk_cnt("R10 after disable", 16'h2);
    ext_pin = 0; step(4); ext_pin = 1; step(4);
    chk_cnt("R10 rearmed", 16'h3);

    // R11 alternate source
    src_sel = 2'b11;
    write16(16'h0000);
    for (int k = 0; k < 3; k++) begin
      alt_tick = 1; step(1); alt_tick = 0; step(2);
    end
    chk_cnt("R11 alt ticks", 16'h3);

    // random mix against model (R2 R4 R5 R6 R7 R8 R9)
    src_sel = 2'b01; run_en = 0;
    write16(16'h0000);
    ovf_clr = 1; step(1); ovf_clr = 0;
    m_cnt = cur(); m_pc = 3'd0; m_flag = 1'b0;
    irq_en = 1;
    for (int c = 0; c < 600; c++) begin
      int r;
      r = int'($urandom_range(0, 15));
      run_en    = ($urandom_range(0, 7) != 0);
      gate_mode = $urandom_range(0, 1) != 0;
      gate_act  = $urandom_range(0, 1) != 0;
      div_sel   = 2'($urandom_range(0, 3));
      wr_hi     = (r == 0);
      wr_lo     = (r == 1);
      evt_clr   = (r == 2);
      ovf_clr   = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 3))
        0: wr_data = 8'hFF;
        1: wr_data = 8'hFE;
        2: wr_data = 8'h00;
        default: wr_data = 8'($urandom);
      endcase
      model_step();
      step(1);
      chk(cur() == m_cnt, "RND count R2 R4 R5 R8 R9", int'(cur()), int'(m_cnt));
      chk(ovf_flag == m_flag && irq == m_flag, "RND flag R6 R7",
          {ovf_flag, irq}, {m_flag, m_flag});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule